// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Controller

This block drives several independent pulse-width-modulated outputs from one input clock. Each channel owns a single 32-bit control word that holds an enable flag, an 8-bit duty value and a 13-bit clock divider. A running channel divides the input clock by (divider + 1) to form a tick. It then runs a frame of 256 ticks, and its pin is high for the first `duty` ticks of each frame.

Software reaches the control words over a plain single-cycle read/write bus. Channel slots lie 16 bytes apart. Only the first word of each slot is backed by storage, and read data is combinational. To change the enable flag and keep the other fields, software reads the word, edits the flag and writes the word back.

A rewrite of duty or divider on a running channel is staged. The channel keeps its current values until the frame in progress ends, so no period is shortened or glitched.

Top module: `mpwm_top`

## Requirements
- R1: After reset every control word reads zero and every output is low.
- R2: A control word keeps the enable flag at bit 31, duty at bits 23:16 and divider at bits 12:0. Readback returns these fields as written, and every other bit reads zero.
- R3: While a channel's enable bit is clear, its output is low and its prescale and frame counters are held at zero.
- R4: A running channel has a period of 256 × (divider + 1) input clocks, and its output is high for duty × (divider + 1) of them.
- R5: A duty of 0 keeps the output low for the whole frame, and a duty of 255 keeps it high for 255 of the 256 ticks.
- R6: A duty or divider written to a running channel is applied only at the next frame boundary. The frame in progress completes with the old values.
- R7: Clearing and then setting only the enable bit through read-modify-write preserves the duty and divider, and the output resumes with them.
- R8: Writing zero to a channel word turns its output off from the next cycle and clears its duty and divider.
- R9: An access to a non-zero offset inside a slot, or to a slot at or above the channel count, reads zero, and a write there changes no control word.
- R10: Channels run independently. Programming one channel does not change another channel's waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock, also the undivided tick source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; the bits from 4 upward select the channel slot |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while sel_i is high and wr_i is low |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
The hardest case to reach from the pins is a rewrite that lands in the middle of a running frame. In that case the old and new duty must both be seen, each in its own frame. The bench locks onto a rising edge of the output to learn the frame phase, since that edge marks tick zero. It writes a larger duty ten ticks in, then samples tick 100 in the same frame and again in the next one. The old duty says low at that tick and the new duty says high, so one early or one late application shows up as a wrong level.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int WORD_W   = 32;
  localparam int EN_BIT   = 31;
  localparam int DUTY_LSB = 16;
  localparam int DUTY_W   = 8;
  localparam int DIV_LSB  = 0;
  localparam int DIV_W    = 13;
  localparam int SLOT_LSB = 4;

  localparam logic [WORD_W-1:0] LIVE_MASK =
      (WORD_W'(1) << EN_BIT)
    | (((WORD_W'(1) << DUTY_W) - WORD_W'(1)) << DUTY_LSB)
    | (((WORD_W'(1) << DIV_W) - WORD_W'(1)) << DIV_LSB);

  typedef struct packed {
    logic              en;
    logic [DUTY_W-1:0] duty;
    logic [DIV_W-1:0]  div;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.en   = w[EN_BIT];
    c.duty = w[DUTY_LSB +: DUTY_W];
    c.div  = w[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] word_from_cfg(input cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EN_BIT]               = c.en;
    w[DUTY_LSB +: DUTY_W]   = c.duty;
    w[DIV_LSB +: DIV_W]     = c.div;
    return w;
  endfunction
endpackage

// File: rtl/mpwm_regs.sv
module mpwm_regs
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sel_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [WORD_W-1:0]       rdata_o,
  output cfg_t [NUM_CH-1:0]       cfg_o
);
  localparam int SLOT_W = ADDR_W - SLOT_LSB;
  localparam logic [SLOT_W:0] SLOT_CNT = (SLOT_W+1)'(NUM_CH);

  logic [SLOT_W-1:0] slot;
  logic              hit;
  cfg_t [NUM_CH-1:0] cfg_q;

  assign slot = addr_i[ADDR_W-1:SLOT_LSB];
  // only word 0 of an existing slot is backed
  assign hit  = (addr_i[SLOT_LSB-1:0] == '0) && ({1'b0, slot} < SLOT_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (sel_i && wr_i && hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (slot == SLOT_W'(c)) cfg_q[c] <= cfg_from_word(wdata_i);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i && hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (slot == SLOT_W'(c)) rdata_o = word_from_cfg(cfg_q[c]);
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan
  import mpwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  output logic pwm_o
);
  logic              run_q;
  logic [DIV_W-1:0]  pre_q;
  logic [DIV_W-1:0]  div_act_q;
  logic [DUTY_W-1:0] frm_q;
  logic [DUTY_W-1:0] duty_act_q;
  logic              tick;
  logic              frame_end;
  logic              load;

  assign tick      = run_q && (pre_q == div_act_q);
  assign frame_end = tick && (frm_q == '1);
  // staged values are taken on start-up or on a frame boundary only
  assign load      = cfg_i.en && (!run_q || frame_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      pre_q      <= '0;
      frm_q      <= '0;
      div_act_q  <= '0;
      duty_act_q <= '0;
    end else if (!cfg_i.en) begin
      run_q <= 1'b0;
      pre_q <= '0;
      frm_q <= '0;
    end else if (load) begin
      run_q      <= 1'b1;
      pre_q      <= '0;
      frm_q      <= '0;
      div_act_q  <= cfg_i.div;
      duty_act_q <= cfg_i.duty;
    end else if (tick) begin
      pre_q <= '0;
      frm_q <= frm_q + DUTY_W'(1);
    end else begin
      pre_q <= pre_q + DIV_W'(1);
    end
  end

  assign pwm_o = cfg_i.en && run_q && (frm_q < duty_act_q);
endmodule

// File: rtl/mpwm_top.sv
module mpwm_top
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  cfg_t [NUM_CH-1:0] cfg;

  mpwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mpwm_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg[c]),
      .pwm_o  (pwm_o[c])
    );
  end
endmodule

// File: rtl/mpwm_chk.sv
module mpwm_top_chk
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sel_i,
  input logic                    wr_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [31:0]             wdata_i,
  input logic [31:0]             rdata_o,
  input logic [NUM_CH-1:0]       pwm_o,
  input logic [NUM_CH*CFG_W-1:0] cfg_flat
);
  localparam int SLOT_W = ADDR_W - SLOT_LSB;
  logic [SLOT_W-1:0] slot;
  logic              mapped;
  logic [NUM_CH-1:0] ch_mask;

  assign slot   = addr_i[ADDR_W-1:SLOT_LSB];
  assign mapped = (addr_i[SLOT_LSB-1:0] == '0) && (int'(slot) < NUM_CH);
  always_comb begin
    ch_mask = '0;
    for (int c = 0; c < NUM_CH; c++) if (mapped && int'(slot) == c) ch_mask[c] = 1'b1;
  end

  assert_rsv_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~LIVE_MASK) == '0);

  assert_zero_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && mapped && wdata_i == '0) |=> ((pwm_o & $past(ch_mask)) == '0));

  assert_unmapped_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && !mapped) |=> $stable(cfg_flat));

  assert_unmapped_rd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && !mapped) |-> rdata_o == '0);
endmodule

module mpwm_chan_chk
  import mpwm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en,
  input logic              run,
  input logic [DIV_W-1:0]  pre,
  input logic [DIV_W-1:0]  div_act,
  input logic [DUTY_W-1:0] frm,
  input logic [DUTY_W-1:0] duty_act,
  input logic              pwm
);
  assert_dis_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !pwm);

  assert_dis_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (pre == '0 && frm == '0));

  assert_tick_rate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && run && pre != div_act) |=> $stable(frm));

  assert_zero_duty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_act == '0) |-> !pwm);

  assert_frame_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && run && !(pre == div_act && frm == '1)) |=> ($stable(duty_act) && $stable(div_act)));
endmodule

bind mpwm_top mpwm_top_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_top_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pwm_o    (pwm_o),
  .cfg_flat (cfg)
);

bind mpwm_chan mpwm_chan_chk u_chan_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en       (cfg_i.en),
  .run      (run_q),
  .pre      (pre_q),
  .div_act  (div_act_q),
  .frm      (frm_q),
  .duty_act (duty_act_q),
  .pwm      (pwm_o)
);

// File: tb/mpwm_top_tb.sv
module mpwm_top_tb;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sel_i = 1'b0;
  logic              wr_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NUM_CH-1:0] pwm_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int    ch;
    int    skip;
    int    win;
    int    exp;
    string tag;
  } item_t;

  item_t sb_q[$];
  int    pend = 0;

  always #5 clk_i = ~clk_i;

  mpwm_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pwm_o   (pwm_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
    #1;
    check(rdata_o == exp, tag, rdata_o, exp);
    sel_i = 1'b0;
  endtask

  // expect `exp` high samples on channel ch over win negedges after skip negedges
  task automatic expect_hi(input int ch, input int skip, input int win, input int exp, input string tag);
    item_t it;
    it.ch = ch; it.skip = skip; it.win = win; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    pend++;
    wait (pend == 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin : monitor
    item_t it;
    int    cnt;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      repeat (it.skip) @(negedge clk_i);
      cnt = 0;
      repeat (it.win) begin
        @(negedge clk_i);
        cnt += int'(pwm_o[it.ch]);
      end
      check(cnt == it.exp, it.tag, cnt, it.exp);
      pend--;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] v;
    logic        prev;
    int          guard;
    idle(5);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset state
    for (int c = 0; c < NUM_CH; c++) bus_rd(ADDR_W'(c * 16), 32'h0, "R1 reset readback");
    check(pwm_o == '0, "R1 outputs low", int'(pwm_o), 0);

    // R2 + R4: duty 64, divider 0
    bus_wr(8'h00, 32'h8040_0000);
    bus_rd(8'h00, 32'h8040_0000, "R2 readback ch0");
    idle(4);
    expect_hi(0, 0, 256, 64, "R4 ch0 d64 p0 one period");
    expect_hi(0, 0, 512, 128, "R4 ch0 d64 p0 two periods");

    // R6: mid-frame duty change waits for frame boundary
    prev = pwm_o[0];
    guard = 0;
    forever begin
      @(negedge clk_i);
      guard++;
      if ((pwm_o[0] && !prev) || guard > 1000) break;
      prev = pwm_o[0];
    end
    idle(9);
    bus_wr(8'h00, 32'h8080_0000);
    expect_hi(0, 89, 1, 0, "R6 old duty held in current frame");
    expect_hi(0, 255, 1, 1, "R6 new duty in next frame");
    expect_hi(0, 0, 256, 128, "R6 new duty full period");

    // R5 duty extremes
    bus_wr(8'h00, 32'h8000_0000);
    idle(300);
    expect_hi(0, 0, 512, 0, "R5 duty zero stays low");
    bus_wr(8'h00, 32'h80FF_0001);
    idle(600);
    expect_hi(0, 0, 512, 510, "R5 duty 255 divider 1");

    // R7 read-modify-write of enable, R3 disabled low
    bus_wr(8'h10, 32'h8040_0002);
    idle(800);
    expect_hi(1, 0, 768, 192, "R4 ch1 d64 p2");
    v = 32'h8040_0002;
    bus_wr(8'h10, v & ~32'h8000_0000);
    bus_rd(8'h10, 32'h0040_0002, "R7 fields kept while disabled");
    expect_hi(1, 0, 600, 0, "R3 disabled channel low");
    bus_wr(8'h10, v);
    idle(10);
    expect_hi(1, 0, 768, 192, "R7 resumes with kept fields");

    // R10 independent channels
    bus_wr(8'h20, 32'h8080_0001);
    idle(10);
    expect_hi(2, 0, 1536, 768, "R10 ch2 d128 p1");
    expect_hi(1, 0, 1536, 384, "R10 ch1 unaffected");
    expect_hi(0, 0, 512, 510, "R10 ch0 unaffected");

    // R9 unmapped offsets and slots
    bus_wr(8'h24, 32'hFFFF_FFFF);
    bus_wr(8'h50, 32'hFFFF_FFFF);
    bus_wr(8'h2C, 32'h0000_0000);
    bus_rd(8'h20, 32'h8080_0001, "R9 ch2 word unchanged");
    bus_rd(8'h24, 32'h0, "R9 inner offset reads zero");
    bus_rd(8'h50, 32'h0, "R9 absent slot reads zero");
    expect_hi(2, 0, 512, 256, "R9 ch2 waveform unchanged");

    // R2 reserved bits read zero
    bus_wr(8'h30, 32'hFFFF_FFFF);
    bus_rd(8'h30, 32'h80FF_1FFF, "R2 reserved bits zero");

    // R8 zero write stops and clears
    bus_wr(8'h30, 32'h0);
    bus_rd(8'h30, 32'h0, "R8 ch3 cleared");
    expect_hi(3, 0, 300, 0, "R8 ch3 low");
    bus_wr(8'h20, 32'h0);
    expect_hi(2, 0, 1000, 0, "R8 running ch2 stops");
    bus_rd(8'h20, 32'h0, "R8 ch2 cleared");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule